// File: doc/BRIEF.md
# Adaptive CAVLC Coefficient Level Decoder

This block turns the level codewords of one 4x4 residual block into signed coefficient values. It decodes only the levels that are not trailing ones, so it emits TotalCoeff minus TrailingOnes values. After each decoded level it updates its choice among seven code tables, numbered 0 to 6. A bit-stream front end supplies a 32-bit window that is MSB-aligned on the next unread bit. The decoder reports every level together with the number of bits it used. The front end must advance its window by that count before the decoder reads again.

Each codeword is a run of zeros, a separating one, and a suffix. The run length selects a first-stage entry that holds three things: the suffix length, a base index into one merged code space, and the table to use for the next level. Adding the suffix to the base gives a code index, and a fixed even/odd rule maps that index to a signed level. When the zero run reaches 16, an arithmetic escape path forms the index from a 13-bit suffix instead. A start pulse loads the counts of the new block. The decoder then accepts one window per level and pulses done together with the final level.

Top module: `cavlc_level_dec`

## Requirements
- R1: While reset is held, and just after it, level_valid, done and busy are low.
- R2: The first level of a block is read with table 1 when TotalCoeff > 10 and TrailingOnes < 3. Otherwise the first level is read with table 0.
- R3: Each level sets the next table. From table 0 the decoder always moves to at least table 1, and moves to table 2 if the magnitude exceeds 3. From table t in 1..5 it moves to t+1 when the magnitude exceeds 3*2^(t-1). Table 6 is kept. The table never goes down within a block.
- R4: With table t and zero run p < 14, the suffix is t bits long and the code index is (p << t) + suffix. An even index k gives +(k+2)/2 and an odd index gives -(k+1)/2. In table 1, for example, 10 gives +1, 11 gives -1, 010 gives +2 and 011 gives -2.
- R5: When TrailingOnes < 3, the first level's code index is raised by 2, which adds one to its magnitude. In table 0, the codeword 1 then gives +2 and 01 gives -2.
- R6: A zero run of 16 takes a 13-bit suffix. The code index is (15 << t) + (15 if t = 0) + 4096 + suffix, and the codeword is 30 bits long.
- R7: A zero run of 14 in table 0 takes a 4-bit suffix on base 14. A zero run of 15 takes a 12-bit suffix on base (15 << t) + (15 if t = 0).
- R8: A level is decoded at a clock edge when busy and win_valid are high and level_valid is low. level_valid is a one-cycle pulse in the next cycle, with bits_used equal to zero run + 1 + suffix length. While win_valid is low, no level is produced.
- R9: done pulses with the last of the TotalCoeff minus TrailingOnes levels, and busy falls at the same time. When the count is zero, done pulses one cycle after start and no level is emitted.
- R10: A start pulse while busy is ignored. The current block's count, table and results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a block; sampled only when idle |
| total_coeff | input | 5 | Non-zero coefficient count of the block (0..16) |
| trailing_ones | input | 2 | Trailing-one count of the block (0..3) |
| win_valid | input | 1 | The window holds the next unread bits |
| win | input | 32 | Bit window, MSB is the next unread bit |
| level_valid | output | 1 | One-cycle pulse: level and bits_used are new |
| level | output | 16 | Signed decoded level |
| bits_used | output | 6 | Bits consumed by this codeword |
| busy | output | 1 | Block in progress |
| done | output | 1 | One-cycle pulse at block end |

## Verification
The assertions assume the front end never shows a zero run longer than 16. They also assume TrailingOnes never exceeds TotalCoeff, and that a window presented after a level_valid pulse has already been shifted by bits_used. The bench meets these assumptions by building each block's bit stream from its own level encoder, which never produces a run longer than 16. It advances its read pointer by the codeword length it computed itself, and it raises win_valid only after the pulse is over. It chooses level values that the encoder can represent, so the first level of a block with TrailingOnes < 3 is never ±1.

// File: rtl/cavlc_lvl_pkg.sv
package cavlc_lvl_pkg;
  localparam int TBL_W   = 3;
  localparam int PFX_W   = 5;
  localparam int REM_W   = 4;
  localparam int CODE_W  = 15;
  localparam int SFX_MAX = 13;
  localparam int ESC_PFX = 16;
  localparam int TBL_TOP = 6;
  localparam int HI_CNT  = 10;
  localparam int ESC_OFS = 4096;

  typedef logic [TBL_W-1:0] tbl_t;

  typedef struct packed {
    logic [REM_W-1:0]  rem_len;
    logic [CODE_W-1:0] base;
    tbl_t              next_tbl;
  } s1_entry_t;

  // Next table from the zero run alone: for a fixed table the magnitude
  // threshold falls exactly on a run-length boundary.
  function automatic tbl_t step_table(tbl_t cur, logic [PFX_W-1:0] pfx, logic adj);
    tbl_t nt;
    if (cur == '0)
      nt = (pfx >= (adj ? PFX_W'(4) : PFX_W'(6))) ? tbl_t'(2) : tbl_t'(1);
    else if (cur < tbl_t'(TBL_TOP))
      nt = (pfx >= (adj ? PFX_W'(2) : PFX_W'(3))) ? cur + tbl_t'(1) : cur;
    else
      nt = cur;
    return nt;
  endfunction

  function automatic s1_entry_t first_stage(tbl_t tbl, logic [PFX_W-1:0] pfx, logic adj);
    s1_entry_t e;
    logic [CODE_W-1:0] clip;
    clip = (pfx >= PFX_W'(15)) ? CODE_W'(15) : CODE_W'(pfx);
    if (pfx >= PFX_W'(15))
      e.rem_len = REM_W'(pfx - PFX_W'(3));
    else if (pfx == PFX_W'(14) && tbl == '0)
      e.rem_len = REM_W'(4);
    else
      e.rem_len = REM_W'(tbl);
    e.base = (clip << tbl)
           + ((pfx >= PFX_W'(15) && tbl == '0) ? CODE_W'(15) : CODE_W'(0))
           + (adj ? CODE_W'(2) : CODE_W'(0));
    e.next_tbl = step_table(tbl, pfx, adj);
    return e;
  endfunction

  function automatic logic [CODE_W-1:0] escape_base(tbl_t tbl, logic adj);
    return (CODE_W'(15) << tbl)
         + ((tbl == '0) ? CODE_W'(15) : CODE_W'(0))
         + CODE_W'(ESC_OFS)
         + (adj ? CODE_W'(2) : CODE_W'(0));
  endfunction

  function automatic logic signed [CODE_W:0] code_to_level(logic [CODE_W-1:0] code);
    logic [CODE_W:0] c;
    logic [CODE_W:0] pos;
    logic [CODE_W:0] neg;
    c   = {1'b0, code};
    pos = (c + (CODE_W+1)'(2)) >> 1;
    neg = (c + (CODE_W+1)'(1)) >> 1;
    return code[0] ? -$signed(neg) : $signed(pos);
  endfunction
endpackage

// File: rtl/cavlc_lz_count.sv
module cavlc_lz_count #(
  parameter int WIN_W = 32,
  parameter int LIMIT = 16,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic [WIN_W-1:0] bits,
  output logic [CNT_W-1:0] zeros
);
  // Saturates at LIMIT; the lowest index holding a one wins.
  always_comb begin
    zeros = CNT_W'(LIMIT);
    for (int i = LIMIT - 1; i >= 0; i--) begin
      if (bits[WIN_W-1-i]) zeros = CNT_W'(i);
    end
  end
endmodule

// File: rtl/cavlc_lvl_decode.sv
module cavlc_lvl_decode
  import cavlc_lvl_pkg::*;
#(
  parameter int WIN_W   = 32,
  parameter int LEVEL_W = 16,
  localparam int BITS_W = $clog2(WIN_W + 1)
) (
  input  logic [WIN_W-1:0]   win,
  input  tbl_t               tbl,
  input  logic               adj,
  output logic [LEVEL_W-1:0] level,
  output logic [BITS_W-1:0]  nbits,
  output tbl_t               next_tbl,
  output logic               escape
);
  logic [PFX_W-1:0]  lz;
  s1_entry_t         s1;
  logic [REM_W-1:0]  rem_len;
  logic [WIN_W-1:0]  after_pfx;
  logic [WIN_W-1:0]  sfx_wide;
  logic [CODE_W-1:0] code;

  cavlc_lz_count #(.WIN_W(WIN_W), .LIMIT(ESC_PFX)) u_lz (
    .bits  (win),
    .zeros (lz)
  );

  always_comb begin
    escape    = (lz == PFX_W'(ESC_PFX));
    s1        = first_stage(tbl, lz, adj);
    rem_len   = escape ? REM_W'(SFX_MAX) : s1.rem_len;
    after_pfx = win << (BITS_W'(lz) + BITS_W'(1));
    sfx_wide  = after_pfx >> (BITS_W'(WIN_W) - BITS_W'(rem_len));
    code      = (escape ? escape_base(tbl, adj) : s1.base)
              + CODE_W'(sfx_wide[SFX_MAX-1:0]);
    next_tbl  = escape ? step_table(tbl, lz, adj) : s1.next_tbl;
    level     = LEVEL_W'(code_to_level(code));
    nbits     = BITS_W'(lz) + BITS_W'(1) + BITS_W'(rem_len);
  end
endmodule

// File: rtl/cavlc_level_dec.sv
module cavlc_level_dec
  import cavlc_lvl_pkg::*;
#(
  parameter int WIN_W     = 32,
  parameter int LEVEL_W   = 16,
  parameter int MAX_COEFF = 16,
  localparam int CNT_W  = $clog2(MAX_COEFF + 1),
  localparam int BITS_W = $clog2(WIN_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CNT_W-1:0]   total_coeff,
  input  logic [1:0]         trailing_ones,
  input  logic               win_valid,
  input  logic [WIN_W-1:0]   win,
  output logic               level_valid,
  output logic [LEVEL_W-1:0] level,
  output logic [BITS_W-1:0]  bits_used,
  output logic               busy,
  output logic               done
);
  logic               busy_q, valid_q, done_q, adj_q;
  logic [CNT_W-1:0]   left_q;
  tbl_t               tbl_q;
  logic [LEVEL_W-1:0] level_q;
  logic [BITS_W-1:0]  bits_q;

  logic               start_fire, dec_fire, last_level;
  logic [CNT_W-1:0]   lvl_count;
  tbl_t               init_tbl;
  logic               init_adj;
  logic [LEVEL_W-1:0] dec_level;
  logic [BITS_W-1:0]  dec_bits;
  tbl_t               dec_next;
  logic               dec_escape;

  assign start_fire = start & ~busy_q;
  assign dec_fire   = busy_q & win_valid & ~valid_q;
  assign last_level = (left_q == CNT_W'(1));
  assign lvl_count  = total_coeff - CNT_W'(trailing_ones);
  assign init_adj   = (trailing_ones < 2'd3);
  assign init_tbl   = (total_coeff > CNT_W'(HI_CNT) && init_adj) ? tbl_t'(1) : tbl_t'(0);

  cavlc_lvl_decode #(.WIN_W(WIN_W), .LEVEL_W(LEVEL_W)) u_dec (
    .win      (win),
    .tbl      (tbl_q),
    .adj      (adj_q),
    .level    (dec_level),
    .nbits    (dec_bits),
    .next_tbl (dec_next),
    .escape   (dec_escape)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      adj_q   <= 1'b0;
      left_q  <= '0;
      tbl_q   <= '0;
      level_q <= '0;
      bits_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      if (start_fire) begin
        left_q <= lvl_count;
        tbl_q  <= init_tbl;
        adj_q  <= init_adj;
        busy_q <= (lvl_count != '0);
        done_q <= (lvl_count == '0);
      end else if (dec_fire) begin
        valid_q <= 1'b1;
        level_q <= dec_level;
        bits_q  <= dec_bits;
        tbl_q   <= dec_next;
        adj_q   <= 1'b0;
        left_q  <= left_q - CNT_W'(1);
        if (last_level) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign level_valid = valid_q;
  assign level       = level_q;
  assign bits_used   = bits_q;
  assign busy        = busy_q;
  assign done        = done_q;
endmodule

// File: rtl/cavlc_level_dec_chk.sv
module cavlc_level_dec_chk #(
  parameter int LEVEL_W = 16,
  parameter int BITS_W  = 6,
  parameter int TBL_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               win_valid,
  input logic               level_valid,
  input logic [LEVEL_W-1:0] level,
  input logic [BITS_W-1:0]  bits_used,
  input logic               busy,
  input logic               done,
  input logic [TBL_W-1:0]   tbl,
  input logic               dec_fire
);
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    level_valid |=> !level_valid); // R8
  AST_VALID_HAS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    level_valid |-> $past(win_valid && busy)); // R8
  AST_BITS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    level_valid |-> (bits_used >= BITS_W'(1) && bits_used <= BITS_W'(30))); // R8
  AST_LEVEL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    level_valid |-> (level != '0)); // R4
  AST_TBL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tbl <= TBL_W'(6)); // R3
  AST_TBL_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (tbl >= $past(tbl))); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !dec_fire) |=> (busy && $stable(tbl))); // R10
endmodule

bind cavlc_level_dec cavlc_level_dec_chk #(
  .LEVEL_W (LEVEL_W),
  .BITS_W  (BITS_W),
  .TBL_W   (cavlc_lvl_pkg::TBL_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .win_valid   (win_valid),
  .level_valid (level_valid),
  .level       (level),
  .bits_used   (bits_used),
  .busy        (busy),
  .done        (done),
  .tbl         (tbl_q),
  .dec_fire    (dec_fire)
);

// File: tb/cavlc_level_dec_tb.sv
`timescale 1ns/1ps
module cavlc_level_dec_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  total_coeff = '0;
  logic [1:0]  trailing_ones = '0;
  logic        win_valid = 1'b0;
  logic [31:0] win = '0;
  logic        level_valid;
  logic [15:0] level;
  logic [5:0]  bits_used;
  logic        busy;
  logic        done;

  int errors = 0;
  int checks = 0;
  int lv[16];
  int elen[16];
  bit sbits[0:1023];
  int nb;

  always #10 clk = ~clk;

  cavlc_level_dec u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .total_coeff(total_coeff),
    .trailing_ones(trailing_ones), .win_valid(win_valid), .win(win),
    .level_valid(level_valid), .level(level), .bits_used(bits_used),
    .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic put(input int val, input int len);
    for (int i = len - 1; i >= 0; i--) begin
      sbits[nb] = val[i];
      nb++;
    end
  endtask

  // Independent encoder: level code index -> zero run, one, suffix.
  task automatic emit(input int sl, input int code, output int len);
    int pfx, rl, sfx, lim;
    if (sl == 0) begin
      if (code < 14)              begin pfx = code; rl = 0;  sfx = 0; end
      else if (code < 30)         begin pfx = 14;   rl = 4;  sfx = code - 14; end
      else if (code - 30 < 4096)  begin pfx = 15;   rl = 12; sfx = code - 30; end
      else                        begin pfx = 16;   rl = 13; sfx = code - 30 - 4096; end
    end else begin
      lim = 15 << sl;
      if (code < lim)                 begin pfx = code >> sl; rl = sl; sfx = code % (1 << sl); end
      else if (code - lim < 4096)     begin pfx = 15; rl = 12; sfx = code - lim; end
      else                            begin pfx = 16; rl = 13; sfx = code - lim - 4096; end
    end
    put(0, pfx);
    put(1, 1);
    put(sfx, rl);
    len = pfx + 1 + rl;
  endtask

  function automatic int next_tbl(input int sl, input int lvl);
    int s, mag;
    mag = (lvl < 0) ? -lvl : lvl;
    s = (sl == 0) ? 1 : sl;
    if (mag > (3 << (s - 1)) && s < 6) s++;
    return s;
  endfunction

  function automatic logic [31:0] window_at(input int ptr);
    logic [31:0] w;
    for (int i = 0; i < 32; i++) w[31-i] = (ptr + i < nb) ? sbits[ptr+i] : 1'b0;
    return w;
  endfunction

  // Runs one block: levels in lv[0..n-1]; tag names the requirement of the values.
  task automatic run_block(input string tag, input int tc, input int t1, input int n,
                           input bit stall, input bit poke);
    int sl, code, ptr;
    nb = 0;
    sl = (tc > 10 && t1 < 3) ? 1 : 0;
    for (int k = 0; k < n; k++) begin
      code = (lv[k] > 0) ? 2 * lv[k] - 2 : -2 * lv[k] - 1;
      if (k == 0 && t1 < 3) code -= 2;
      emit(sl, code, elen[k]);
      sl = next_tbl(sl, lv[k]);
    end
    @(negedge clk);
    total_coeff = 5'(tc); trailing_ones = 2'(t1); start = 1'b1; win_valid = 1'b0;
    @(negedge clk);
    start = 1'b0;
    if (n == 0) begin
      chk(done == 1'b1, "R9", "done on empty block", int'(done), 1);
      chk(level_valid == 1'b0 && busy == 1'b0, "R9", "no level on empty block",
          int'(level_valid), 0);
      @(negedge clk);
      chk(done == 1'b0, "R9", "done pulse width", int'(done), 0);
      return;
    end
    ptr = 0;
    for (int k = 0; k < n; k++) begin
      if (stall) begin
        win_valid = 1'b0;
        if (poke && k == 1) begin
          total_coeff = 5'd16; trailing_ones = 2'd0; start = 1'b1;
        end
        for (int c = 0; c < 3; c++) begin
          @(negedge clk);
          chk(level_valid == 1'b0, "R8", "no level while window invalid", int'(level_valid), 0);
        end
        start = 1'b0;
        if (poke && k == 1)
          chk(busy == 1'b1, "R10", "busy kept through ignored start", int'(busy), 1);
      end
      win = window_at(ptr);
      win_valid = 1'b1;
      @(negedge clk);
      chk(level_valid == 1'b1, "R8", $sformatf("level_valid idx %0d", k), int'(level_valid), 1);
      chk(int'($signed(level)) == lv[k], tag, $sformatf("level idx %0d", k),
          int'($signed(level)), lv[k]);
      chk(int'(bits_used) == elen[k], "R8", $sformatf("bits_used idx %0d", k),
          int'(bits_used), elen[k]);
      chk(done == (k == n - 1), "R9", $sformatf("done idx %0d", k), int'(done),
          int'(k == n - 1));
      ptr += elen[k];
      win_valid = 1'b0;
      @(negedge clk);
    end
    chk(busy == 1'b0 && level_valid == 1'b0, "R9", "idle after block", int'(busy), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(level_valid == 1'b0 && done == 1'b0 && busy == 1'b0, "R1", "outputs in reset",
        int'({level_valid, done, busy}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(level_valid == 1'b0 && done == 1'b0 && busy == 1'b0, "R1", "outputs after reset",
        int'({level_valid, done, busy}), 0);
  endtask

  task automatic t_table1_codes();   // R4: 1, 10, 11, 010, 011
    lv[0] = 2; lv[1] = 1; lv[2] = -1; lv[3] = 2; lv[4] = -2;
    run_block("R4", 6, 1, 5, 1'b0, 1'b0);
  endtask

  task automatic t_first_adjust();   // R5
    lv[0] = -2; lv[1] = 3;
    run_block("R5", 2, 0, 2, 1'b0, 1'b0);
    lv[0] = 9;
    run_block("R5", 3, 2, 1, 1'b0, 1'b0);
  endtask

  task automatic t_init_table1();    // R2 and R3 growth
    lv[0] = 5;   lv[1] = -3;  lv[2] = 7;   lv[3] = 10;  lv[4] = -20; lv[5] = 30;
    lv[6] = -60; lv[7] = 100; lv[8] = -200; lv[9] = 3;  lv[10] = 1;
    run_block("R2", 12, 1, 11, 1'b0, 1'b0);
  endtask

  task automatic t_thresholds();     // R3 boundary at magnitude 3 vs 4 in table 0
    lv[0] = 4;  lv[1] = 5;
    run_block("R3", 5, 3, 2, 1'b0, 1'b0);
    lv[0] = -3; lv[1] = 5;
    run_block("R3", 5, 3, 2, 1'b0, 1'b0);
    lv[0] = 2;  lv[1] = 4; lv[2] = 7; lv[3] = 6; lv[4] = -13;
    run_block("R3", 5, 0, 5, 1'b0, 1'b0);
  endtask

  task automatic t_long_prefix();    // R7
    lv[0] = 8;
    run_block("R7", 4, 3, 1, 1'b0, 1'b0);
    lv[0] = 20;
    run_block("R7", 4, 3, 1, 1'b0, 1'b0);
    lv[0] = -7;
    run_block("R7", 4, 3, 1, 1'b0, 1'b0);
  endtask

  task automatic t_escape();         // R6
    lv[0] = 2064; lv[1] = -3000; lv[2] = 5000; lv[3] = -1;
    lv[4] = 1;    lv[5] = 12;    lv[6] = -49;  lv[7] = 6000;
    run_block("R6", 11, 3, 8, 1'b0, 1'b0);
  endtask

  task automatic t_stall_and_poke(); // R8, R10
    lv[0] = 3; lv[1] = -4; lv[2] = 6;
    run_block("R10", 4, 1, 3, 1'b1, 1'b1);
  endtask

  task automatic t_empty();          // R9
    run_block("R9", 2, 2, 0, 1'b0, 1'b0);
    run_block("R9", 0, 0, 0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_table1_codes();
    t_first_adjust();
    t_init_table1();
    t_thresholds();
    t_long_prefix();
    t_escape();
    t_stall_and_poke();
    t_empty();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule